// File: doc/BRIEF.md
# Serial Frame Receiver with Hold Register and Error Flags

This block turns an asynchronous serial line into bytes. A free-running enable that pulses sixteen times per bit period paces it. A frame has one low start bit, then seven or eight data bits with the least significant bit first, then an optional parity bit of either sense, then one high stop bit. Once a frame is complete, the byte goes into a hold register. The host reads that register by pulling its output-enable and select strobes low together.

Four status outputs go with the hold register: byte-ready, parity fault, overrun and frame fault. A single read clears all four together. If a new frame completes while the previous byte is still unread, the old byte is kept and the new one is lost. A build-time option, `LEGACY_READY`, raises byte-ready as soon as the last data or parity bit is captured. In that mode the stop-bit check is reported one bit period later.

Top module: `serial_rx_unit`

## Requirements
- R1: The line passes through two synchronising flops. A low seen on an enable pulse while idle is rechecked 8 enable pulses later. If the line is high by then, the receiver returns to idle and nothing is reported.
- R2: Data bits are sampled every 16 enable pulses after the confirmed start. They are assembled least significant bit first and, in 8-bit mode (`width8`=1), the byte appears on `rx_byte`.
- R3: In 7-bit mode (`width8`=0), seven data bits are taken and parity or stop follows bit 6. `rx_byte[7]` reads 0.
- R4: With `par_on`=1, a parity bit follows the data. `par_odd`=0 demands an even count of ones over data plus parity, and `par_odd`=1 demands an odd count. A mismatch sets `parity_fault`. With `par_on`=0 no parity bit is taken and `parity_fault` stays 0.
- R5: A stop bit sampled low sets `frame_fault`. In the default mode this happens in the same cycle that `byte_ready` rises.
- R6: `byte_ready` stays high until a read, which is `rd_oe_n` and `rd_cs_n` both low in one cycle. The read clears `byte_ready`, `parity_fault`, `overrun` and `frame_fault` on the next edge. Either strobe low on its own changes nothing.
- R7: A frame that completes while `byte_ready` is high and no read is present sets `overrun`. `rx_byte`, `parity_fault` and `frame_fault` keep their values.
- R8: A read in the same cycle as a frame completion accepts the new frame. `byte_ready` stays 1, `overrun` is 0 and `rx_byte` takes the new byte.
- R9: With `LEGACY_READY`=1, `byte_ready`, `rx_byte` and `parity_fault` update when the last payload bit is captured. `frame_fault` is set one bit period later, when the stop bit is sampled, and only for a frame that was accepted.
- R10: After reset, all four flags and `rx_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| width8 | input | 1 | 1: eight data bits, 0: seven |
| par_on | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even |
| rd_oe_n | input | 1 | Read output enable, active low |
| rd_cs_n | input | 1 | Read select, active low |
| rx_byte | output | 8 | Held received byte |
| byte_ready | output | 1 | Unread byte present |
| parity_fault | output | 1 | Parity mismatch on held frame |
| overrun | output | 1 | A frame was dropped while a byte was unread |
| frame_fault | output | 1 | Stop bit sampled low |

## Verification
A host read and the completion of a new frame can land in the same clock cycle. In that cycle, clearing the flags and loading the hold register compete. The bench leaves a byte unread, sends a second frame and pulls both read strobes low in exactly the cycle in which its reference model announces the load. It then expects the new byte with `byte_ready` still set and no overrun in the default build. In the legacy build, the same read meets an already overflowed register.

// File: rtl/serial_rx_pkg.sv
// Package: shared types for the serial frame receiver.
// Assumes nothing beyond IEEE 1800-2017 enums.
package serial_rx_pkg;
    // Receive sequencer phases, in frame order.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_DATA   = 3'd2,
        PH_PARITY = 3'd3,
        PH_STOP   = 3'd4
    } rx_phase_e;
endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of STAGES flops. Assumes STAGES >= 2; the chain resets to the
// idle (high) line level.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync
);
    logic [STAGES-1:0] chain;

    // Shift the line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_async};
    end

    assign line_sync = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
// Module: rx_frame_engine
// Walks one frame: confirms the start bit at its middle, samples every
// later bit at the end of an OVS-tick window, assembles data LSB first,
// and emits one-cycle registered strobes when the payload (data plus any
// parity) and the stop bit have been captured. Assumes width/parity
// settings are stable for the duration of a frame.
module rx_frame_engine
    import serial_rx_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int DMAX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            line,
    input  logic            wide,
    input  logic            par_on,
    input  logic            par_odd,
    output logic [DMAX-1:0] word,
    output logic            par_bad,
    output logic            stop_good,
    output logic            payload_stb,
    output logic            stop_stb
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DMAX);
    localparam logic [CW-1:0] MID_TICK  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST_TICK = CW'(OVS - 1);

    rx_phase_e    ph;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic          par_bit;
    logic [IW-1:0] last_idx;

    // Index of the final data bit for the selected width.
    assign last_idx = wide ? IW'(DMAX - 1) : IW'(DMAX - 2);

    // Parity check over held data and captured parity bit.
    assign par_bad = par_on && ((^word ^ par_bit) != par_odd);

    // Frame sequencer with bit counter, shift assembly and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph          <= PH_IDLE;
            cnt         <= '0;
            idx         <= '0;
            word        <= '0;
            par_bit     <= 1'b0;
            stop_good   <= 1'b1;
            payload_stb <= 1'b0;
            stop_stb    <= 1'b0;
        end else begin
            payload_stb <= 1'b0;
            stop_stb    <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (tick && !line) begin
                        ph  <= PH_START;
                        cnt <= '0;
                    end
                end
                PH_START: begin
                    if (tick) begin
                        if (cnt == MID_TICK) begin
                            if (!line) begin
                                ph   <= PH_DATA;
                                cnt  <= '0;
                                idx  <= '0;
                                word <= '0;
                            end else begin
                                ph <= PH_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (tick) begin
                        if (cnt == LAST_TICK) begin
                            cnt       <= '0;
                            word[idx] <= line;
                            if (idx == last_idx) begin
                                if (par_on) begin
                                    ph <= PH_PARITY;
                                end else begin
                                    ph          <= PH_STOP;
                                    payload_stb <= 1'b1;
                                end
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_PARITY: begin
                    if (tick) begin
                        if (cnt == LAST_TICK) begin
                            cnt         <= '0;
                            par_bit     <= line;
                            payload_stb <= 1'b1;
                            ph          <= PH_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_STOP: begin
                    if (tick) begin
                        if (cnt == LAST_TICK) begin
                            cnt       <= '0;
                            stop_good <= line;
                            stop_stb  <= 1'b1;
                            ph        <= PH_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // A start low that has gone high by mid-bit is dropped (R1).
    assert_false_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_START && tick && cnt == MID_TICK && line) |=> (ph == PH_IDLE));

    // The two strobes never coincide; the payload always precedes the stop (R9).
    assert_strobes_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(payload_stb && stop_stb));

    // After the payload strobe the sequencer is waiting for the stop bit (R2).
    assert_payload_then_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        payload_stb |-> (ph == PH_STOP));

    // Seven-bit frames leave the top data bit clear (R3).
    assert_top_bit_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_STOP && !wide) |-> !word[DMAX-1]);
endmodule

// File: rtl/rx_hold_status.sv
// Module: rx_hold_status
// Hold register and the four status flags. LEGACY picks whether the load
// happens on the payload strobe or on the stop strobe. A host read
// (both strobes low) clears every flag; a load that meets an unread byte
// only raises the overrun flag. Assumes strobes are single-cycle.
module rx_hold_status #(
    parameter bit LEGACY = 1'b0,
    parameter int DMAX   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_oe_n,
    input  logic            rd_cs_n,
    input  logic [DMAX-1:0] word,
    input  logic            par_bad,
    input  logic            stop_good,
    input  logic            payload_stb,
    input  logic            stop_stb,
    output logic [DMAX-1:0] out_byte,
    output logic            ready,
    output logic            par_flag,
    output logic            ovf_flag,
    output logic            frm_flag
);
    logic rd;
    logic busy;
    logic load;
    logic frm_late;

    assign rd   = !rd_oe_n && !rd_cs_n;
    assign busy = ready && !rd;

    generate
        if (LEGACY) begin : g_early
            logic took;

            // Load as soon as the payload is in.
            assign load = payload_stb;

            // Remember whether the current frame reached the hold register.
            always_ff @(posedge clk) begin
                if (!rst_n)    took <= 1'b0;
                else if (load) took <= !busy;
            end

            // Stop-bit failure of an accepted frame is reported late.
            assign frm_late = stop_stb && took && !stop_good;
        end else begin : g_late
            // Load once the stop bit is in.
            assign load     = stop_stb;
            assign frm_late = 1'b0;
        end
    endgenerate

    // Hold register and flag update: load, overrun or read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= '0;
            ready    <= 1'b0;
            par_flag <= 1'b0;
            ovf_flag <= 1'b0;
            frm_flag <= 1'b0;
        end else begin
            if (load) begin
                if (busy) begin
                    ovf_flag <= 1'b1;
                end else begin
                    out_byte <= word;
                    ready    <= 1'b1;
                    par_flag <= par_bad;
                    ovf_flag <= 1'b0;
                    frm_flag <= LEGACY ? 1'b0 : !stop_good;
                end
            end else if (rd) begin
                ready    <= 1'b0;
                par_flag <= 1'b0;
                ovf_flag <= 1'b0;
                frm_flag <= 1'b0;
            end
            if (frm_late) frm_flag <= 1'b1;
        end
    end

    // Unread byte stays flagged until a read (R6).
    assert_ready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rd) |=> ready);

    // Read without a load clears ready, parity and overrun (R6).
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> (!ready && !par_flag && !ovf_flag));

    // Overrun keeps the older byte (R7).
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ready && !rd) |=> ($stable(out_byte) && ovf_flag));

    // Read meeting a load accepts the new frame (R8).
    assert_collision_accepts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rd) |=> (ready && !ovf_flag));

    // Default build: frame fault only appears with a held byte (R5).
    assert_frame_with_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!LEGACY && $rose(frm_flag)) |-> ready);

    // Strobes arrive one at a time (R9).
    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        payload_stb |-> !stop_stb);
endmodule

// File: rtl/serial_rx_unit.sv
// Module: serial_rx_unit (top)
// Serial frame receiver: synchroniser, frame engine and hold/status
// register. Assumes os_tick pulses OVS times per bit period and that the
// mode inputs only change while the line is idle.
module serial_rx_unit #(
    parameter bit LEGACY_READY = 1'b0,
    parameter int OVS          = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int DATA_MAX     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rx_in,
    input  logic                width8,
    input  logic                par_on,
    input  logic                par_odd,
    input  logic                rd_oe_n,
    input  logic                rd_cs_n,
    output logic [DATA_MAX-1:0] rx_byte,
    output logic                byte_ready,
    output logic                parity_fault,
    output logic                overrun,
    output logic                frame_fault
);
    logic                line_s;
    logic [DATA_MAX-1:0] word;
    logic                par_bad;
    logic                stop_good;
    logic                payload_stb;
    logic                stop_stb;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (rx_in),
        .line_sync  (line_s)
    );

    rx_frame_engine #(.OVS(OVS), .DMAX(DATA_MAX)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (os_tick),
        .line        (line_s),
        .wide        (width8),
        .par_on      (par_on),
        .par_odd     (par_odd),
        .word        (word),
        .par_bad     (par_bad),
        .stop_good   (stop_good),
        .payload_stb (payload_stb),
        .stop_stb    (stop_stb)
    );

    rx_hold_status #(.LEGACY(LEGACY_READY), .DMAX(DATA_MAX)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_oe_n     (rd_oe_n),
        .rd_cs_n     (rd_cs_n),
        .word        (word),
        .par_bad     (par_bad),
        .stop_good   (stop_good),
        .payload_stb (payload_stb),
        .stop_stb    (stop_stb),
        .out_byte    (rx_byte),
        .ready       (byte_ready),
        .par_flag    (parity_fault),
        .ovf_flag    (overrun),
        .frm_flag    (frame_fault)
    );
endmodule

// File: tb/sim_serial_rx_unit.sv
// Behavioural reference: counts enable pulses, queues sampled bits and
// decodes the frame when enough have arrived; then applies the flag rules.
module rx_ref_model #(
    parameter bit LEGACY = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic       wide,
    input  logic       pon,
    input  logic       podd,
    input  logic       oe_n,
    input  logic       cs_n,
    output logic [7:0] e_byte,
    output logic       e_ready,
    output logic       e_par,
    output logic       e_ovf,
    output logic       e_frm,
    output logic       load_next
);
    bit s1, s2, pay_q, stop_q, pay_n, stop_n, stop_ok, took, pperr, rd, ld, busy;
    int phase, ticks, nb, need, ones;
    bit got[$];
    logic [7:0] pbyte;

    always @(posedge clk) begin
        if (!rst_n) begin
            s1 = 1; s2 = 1; pay_q = 0; stop_q = 0; stop_ok = 1; took = 0;
            phase = 0; ticks = 0; got.delete(); pbyte = 0; pperr = 0;
            e_byte = 0; e_ready = 0; e_par = 0; e_ovf = 0; e_frm = 0;
        end else begin
            // flag rules on last cycle's events
            rd   = !oe_n && !cs_n;
            ld   = LEGACY ? pay_q : stop_q;
            busy = e_ready && !rd;
            if (ld) begin
                if (busy) begin e_ovf = 1; took = 0; end
                else begin
                    e_byte = pbyte; e_ready = 1; e_par = pperr; e_ovf = 0;
                    e_frm = LEGACY ? 1'b0 : !stop_ok; took = 1;
                end
            end else if (rd) begin
                e_ready = 0; e_par = 0; e_ovf = 0; e_frm = 0;
            end
            if (LEGACY && stop_q && took && !stop_ok) e_frm = 1;
            // frame timing
            nb = wide ? 8 : 7;
            need = nb + (pon ? 1 : 0);
            pay_n = 0; stop_n = 0;
            if (phase == 0) begin
                if (tick && !s2) begin phase = 1; ticks = 0; end
            end else if (phase == 1) begin
                if (tick) begin
                    ticks++;
                    if (ticks == 8) begin
                        if (!s2) begin phase = 2; ticks = 0; got.delete(); end
                        else phase = 0;
                    end
                end
            end else if (tick) begin
                ticks++;
                if (ticks == 16) begin
                    ticks = 0;
                    if (got.size() < need) begin
                        got.push_back(s2);
                        if (got.size() == need) begin
                            pbyte = 0;
                            for (int i = 0; i < nb; i++) pbyte[i] = got[i];
                            ones = $countones(pbyte);
                            pperr = pon && ((((ones + int'(got[nb])) % 2) == 1) != podd);
                            pay_n = 1;
                        end
                    end else begin
                        stop_ok = s2; stop_n = 1; phase = 0;
                    end
                end
            end
            pay_q = pay_n; stop_q = stop_n;
            s2 = s1; s1 = rx;
        end
        load_next = LEGACY ? pay_q : stop_q;
    end
endmodule

module sim_serial_rx_unit;
    logic clk = 0, rst_n = 0, tick = 0, rx = 1;
    logic wide = 1, pon = 0, podd = 0, oe_n = 1, cs_n = 1;
    logic [7:0] b0, b1, mb0, mb1;
    logic r0, p0, v0, f0, r1, p1, v1, f1;
    logic mr0, mp0, mv0, mf0, mr1, mp1, mv1, mf1, ld0, ld1;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    serial_rx_unit #(.LEGACY_READY(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(tick), .rx_in(rx), .width8(wide),
        .par_on(pon), .par_odd(podd), .rd_oe_n(oe_n), .rd_cs_n(cs_n),
        .rx_byte(b0), .byte_ready(r0), .parity_fault(p0), .overrun(v0), .frame_fault(f0));
    serial_rx_unit #(.LEGACY_READY(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .os_tick(tick), .rx_in(rx), .width8(wide),
        .par_on(pon), .par_odd(podd), .rd_oe_n(oe_n), .rd_cs_n(cs_n),
        .rx_byte(b1), .byte_ready(r1), .parity_fault(p1), .overrun(v1), .frame_fault(f1));
    rx_ref_model #(.LEGACY(1'b0)) m0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx), .wide(wide), .pon(pon), .podd(podd),
        .oe_n(oe_n), .cs_n(cs_n), .e_byte(mb0), .e_ready(mr0), .e_par(mp0), .e_ovf(mv0),
        .e_frm(mf0), .load_next(ld0));
    rx_ref_model #(.LEGACY(1'b1)) m1 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx), .wide(wide), .pon(pon), .podd(podd),
        .oe_n(oe_n), .cs_n(cs_n), .e_byte(mb1), .e_ready(mr1), .e_par(mp1), .e_ovf(mv1),
        .e_frm(mf1), .load_next(ld1));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // oversampling enable: every other cycle
    always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;

    // cycle-by-cycle comparison against the reference models
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 u0 rx_byte", b0, mb0);
            chk("R6 u0 byte_ready", r0, mr0);
            chk("R4 u0 parity_fault", p0, mp0);
            chk("R7 u0 overrun", v0, mv0);
            chk("R5 u0 frame_fault", f0, mf0);
            chk("R9 u1 rx_byte", b1, mb1);
            chk("R9 u1 byte_ready", r1, mr1);
            chk("R4 u1 parity_fault", p1, mp1);
            chk("R7 u1 overrun", v1, mv1);
            chk("R9 u1 frame_fault", f1, mf1);
        end
    end

    task automatic hold_bit();
        repeat (32) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] v, input bit flip_par, input bit bad_stop);
        logic p;
        int n;
        n = wide ? 8 : 7;
        p = podd;
        @(negedge clk) rx = 0;
        hold_bit();
        for (int i = 0; i < n; i++) begin
            rx = v[i];
            p = p ^ v[i];
            hold_bit();
        end
        if (pon) begin
            rx = p ^ flip_par;
            hold_bit();
        end
        rx = !bad_stop;
        hold_bit();
        rx = 1;
        repeat (64) @(negedge clk);
    endtask

    task automatic host_read();
        @(negedge clk) begin oe_n = 0; cs_n = 0; end
        @(negedge clk) begin oe_n = 1; cs_n = 1; end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rx_byte", b0, 0); chk("R10 byte_ready", r0, 0);
        chk("R10 parity_fault", p0, 0); chk("R10 overrun", v0, 0);
        chk("R10 frame_fault", f0 | f1 | r1 | v1 | p1, 0);

        // R2 8-bit, no parity
        wide = 1; pon = 0;
        send(8'hA5, 0, 0);
        chk("R2 byte", b0, 8'hA5); chk("R2 ready", r0, 1); chk("R4 no parity flag", p0, 0);
        // R6 one strobe alone is not a read
        @(negedge clk) oe_n = 0;
        @(negedge clk) begin oe_n = 1; cs_n = 0; end
        @(negedge clk) cs_n = 1;
        chk("R6 lone strobe keeps ready", r0, 1);
        host_read();
        chk("R6 read clears ready", r0, 0);

        // R4 even parity, good then bad
        pon = 1; podd = 0;
        send(8'h3C, 0, 0);
        chk("R4 even ok", p0, 0); chk("R4 even byte", b0, 8'h3C);
        host_read();
        send(8'h3D, 1, 0);
        chk("R4 even mismatch", p0, 1);
        host_read();
        chk("R6 parity cleared", p0, 0);
        // R4 odd parity
        podd = 1;
        send(8'h01, 0, 0);
        chk("R4 odd ok", p0, 0); chk("R4 odd byte", b0, 8'h01);
        host_read();

        // R3 seven-bit frame with even parity
        wide = 0; podd = 0;
        send(8'hDA, 0, 0);
        chk("R3 seven-bit byte", b0, 8'h5A); chk("R3 parity", p0, 0);
        host_read();

        // R5 bad stop, plus R9 legacy ordering
        wide = 1; pon = 0;
        fork
            send(8'h81, 0, 1);
            begin
                do @(negedge clk); while (!r1);
                chk("R9 legacy ready before default", r0, 0);
                chk("R9 no frame flag yet", f1, 0);
                chk("R9 early byte", b1, 8'h81);
                do @(negedge clk); while (!r0);
                chk("R5 frame with ready", f0, 1);
                chk("R9 late frame flag", f1, 1);
            end
        join
        host_read();
        chk("R6 frame cleared", f0, 0);

        // R7 overflow
        send(8'h11, 0, 0);
        send(8'h22, 0, 0);
        chk("R7 overrun set", v0, 1); chk("R7 older byte kept", b0, 8'h11);
        host_read();
        chk("R6 overrun cleared", v0, 0);

        // R1 short low pulse
        @(negedge clk) rx = 0;
        repeat (6) @(negedge clk);
        rx = 1;
        repeat (80) @(negedge clk);
        chk("R1 glitch ignored", r0, 0);

        // R8 read in the load cycle
        send(8'h33, 0, 0);
        fork
            send(8'h44, 0, 0);
            begin
                do @(negedge clk); while (!ld0);
                oe_n = 0; cs_n = 0;
                @(negedge clk) begin oe_n = 1; cs_n = 1; end
            end
        join
        chk("R8 ready kept", r0, 1); chk("R8 no overrun", v0, 0);
        chk("R8 new byte", b0, 8'h44);
        host_read();

        done = 1;
        summary();
        $finish;
    end
endmodule